// File: doc/BRIEF.md
# Periodic Self-Test Scheduler

This block is the control unit that paces the on-chip self-test of a metering
datapath. It runs a fixed frame made of four equal phases and keeps a frame
counter that advances once per frame. The low bits of that counter form a test
code. When the third phase ends, the code picks the unit that is tested before
the fourth phase starts. Codes for arithmetic units start a test in both running
modes. Codes for filters start a test only in test mode.

A test raises one select line toward the unit or its filter-test controller.
The frame then stops until the matching done input arrives with a pass/fail
flag. One update cycle follows. In that cycle the scheduler records the result
in a per-unit history, sets the unit's status bit when the unit has failed two
tests in a row, and raises a one-clock error pulse on any failure. Two mode pins
choose between reset, initialization, normal and test operation. The status
register keeps its value through every mode and clears only on the reset input.

Top module: `selftest_sched`

## Requirements
- R1: A frame lasts 4*PHASE_LEN clocks when no test runs. `phase_o` reads 0, 1, 2, 3 for PHASE_LEN clocks each. While a test is waiting for its done input, `phase_o` holds 3 and the frame does not advance.
- R2: `frame_o` rises by one at the end of every frame and wraps to 0 after 2^FRAME_W - 1.
- R3: At the end of phase 2, codes 1 to N_ARITH (low CODE_W bits of `frame_o`) raise `arith_sel[code-1]` in normal and test mode. The line stays high until `arith_done` is sampled high.
- R4: Codes N_ARITH+1 to N_ARITH+N_FILT raise `filt_sel[code-N_ARITH-1]` only in test mode. With the defaults, codes 10..14 select, in order: voltage sinc, current sinc, voltage FIR, current FIR, Hilbert. The line stays high until `filt_done` is sampled high.
- R5: Code 0, the all-ones code, and filter codes in normal mode start no test. At most one select line is ever high.
- R6: `status_o[n]` holds the result for code n, so the current-channel sinc result is bit 11. The bit sets in the update cycle of a failing test whose previous test of the same unit also failed. A passing test clears that unit's failure history.
- R7: Every failed test gives exactly one clock of `err_pulse_o`. The pulse is high in the second clock after the clock in which done was sampled high. The status update appears in that same clock.
- R8: Mode pins encode 00 reset, 01 initialization, 10 normal, 11 test. In 00 and 01 the frame and phase counters are held at 0 and no select is high.
- R9: The status register is zero after `rst_n` and keeps its bits through the reset and initialization modes. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pins | input | 2 | Operating mode pins (00 reset, 01 init, 10 normal, 11 test) |
| arith_done | input | 1 | Arithmetic-unit test finished |
| arith_fail | input | 1 | Result flag qualified by `arith_done` (1 = fail) |
| filt_done | input | 1 | Filter test finished |
| filt_fail | input | 1 | Result flag qualified by `filt_done` (1 = fail) |
| phase_o | output | 2 | Current phase of the frame |
| frame_o | output | FRAME_W (12) | Frame counter |
| arith_sel | output | N_ARITH (9) | One-hot arithmetic-unit test select |
| filt_sel | output | N_FILT (5) | One-hot filter test select |
| status_o | output | N_ARITH+N_FILT (14), bits [14:1] | Sticky double-failure status, bit n = code n |
| err_pulse_o | output | 1 | One-clock pulse per failed test |

## Verification
A select line is first visible one clock after the last clock of phase 2, and
the done pulse is driven at that point or after a few extra waiting clocks. The
error pulse and the new status value are due two clocks after done is applied,
and the pulse must be low again one clock later. The bench drives every input on
the falling edge and samples at that same falling edge, a fixed number of edges
after each stimulus, using the cycle counts given above.

The bench sweeps every code in normal mode, then in test mode through a full
counter wrap. It computes the expected unit, frame number, phase and status
history arithmetically for each frame.

// File: rtl/selftest_sched_pkg.sv
package selftest_sched_pkg;
   typedef enum logic [1:0] {
      MD_RESET  = 2'b00,
      MD_INIT   = 2'b01,
      MD_NORMAL = 2'b10,
      MD_TEST   = 2'b11
   } op_mode_e;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_WAIT = 2'd1,
      ST_UPD  = 2'd2
   } sched_st_e;
endpackage

// File: rtl/selftest_mode_dec.sv
module selftest_mode_dec
   import selftest_sched_pkg::*;
(
   input  logic [1:0] mode_pins,
   output logic       run_o,
   output logic       test_o
);
   op_mode_e mode;

   always_comb begin
      mode   = op_mode_e'(mode_pins);
      run_o  = (mode == MD_NORMAL) || (mode == MD_TEST);
      test_o = (mode == MD_TEST);
   end
endmodule

// File: rtl/selftest_frame_timer.sv
module selftest_frame_timer #(
   parameter int PHASE_LEN = 256,
   parameter int FRAME_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               adv,
   output logic [1:0]         phase_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic               t_end_o
);
   localparam int FRAME_LEN = 4 * PHASE_LEN;
   localparam int PCNT_W    = $clog2(FRAME_LEN);
   localparam logic [PCNT_W-1:0] T_LAST = PCNT_W'(3 * PHASE_LEN - 1);
   localparam logic [PCNT_W-1:0] F_LAST = PCNT_W'(FRAME_LEN - 1);

   logic [PCNT_W-1:0]  pcnt_q;
   logic [FRAME_W-1:0] frame_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q  <= '0;
         frame_q <= '0;
      end else if (!run) begin
         pcnt_q  <= '0;
         frame_q <= '0;
      end else if (adv) begin
         if (pcnt_q == F_LAST) begin
            pcnt_q  <= '0;
            frame_q <= frame_q + 1'b1;
         end else begin
            pcnt_q  <= pcnt_q + 1'b1;
         end
      end
   end

   generate
      if ((PHASE_LEN & (PHASE_LEN - 1)) == 0) begin : g_pow2
         assign phase_o = pcnt_q[PCNT_W-1 -: 2];
      end else begin : g_div
         assign phase_o = 2'(pcnt_q / PCNT_W'(PHASE_LEN));
      end
   endgenerate

   assign frame_o = frame_q;
   assign t_end_o = adv && (pcnt_q == T_LAST);
endmodule

// File: rtl/selftest_fail_track.sv
module selftest_fail_track #(
   parameter int N_UNITS = 14,
   parameter int CODE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [CODE_W-1:0] code,
   input  logic              fail,
   output logic [N_UNITS:1]  status_o
);
   generate
      for (genvar u = 1; u <= N_UNITS; u++) begin : g_unit
         logic prev_q, stat_q;
         logic hit;
         assign hit = upd && (code == CODE_W'(u));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               stat_q <= 1'b0;
            end else if (hit) begin
               prev_q <= fail;
               if (fail && prev_q) stat_q <= 1'b1;
            end
         end
         assign status_o[u] = stat_q;
      end
   endgenerate
endmodule

// File: rtl/selftest_sched.sv
module selftest_sched
   import selftest_sched_pkg::*;
#(
   parameter int PHASE_LEN = 256,
   parameter int FRAME_W   = 12,
   parameter int CODE_W    = 4,
   parameter int N_ARITH   = 9,
   parameter int N_FILT    = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 mode_pins,
   input  logic                       arith_done,
   input  logic                       arith_fail,
   input  logic                       filt_done,
   input  logic                       filt_fail,
   output logic [1:0]                 phase_o,
   output logic [FRAME_W-1:0]         frame_o,
   output logic [N_ARITH-1:0]         arith_sel,
   output logic [N_FILT-1:0]          filt_sel,
   output logic [N_ARITH+N_FILT:1]    status_o,
   output logic                       err_pulse_o
);
   localparam int N_UNITS = N_ARITH + N_FILT;
   localparam int FILT_LO = N_ARITH + 1;
   localparam logic [CODE_W-1:0] AR_HI = CODE_W'(N_ARITH);
   localparam logic [CODE_W-1:0] FL_LO = CODE_W'(FILT_LO);
   localparam logic [CODE_W-1:0] FL_HI = CODE_W'(N_UNITS);

   generate
      if (N_UNITS >= (2 ** CODE_W) - 1) begin : g_bad_code
         $error("unit count leaves no idle code");
      end
      if (CODE_W > FRAME_W) begin : g_bad_frame
         $error("code field wider than frame counter");
      end
      if (PHASE_LEN < 2) begin : g_bad_phase
         $error("phase length below two clocks");
      end
   endgenerate

   logic run, test_en, t_end;
   sched_st_e st_q;
   logic [CODE_W-1:0] code_now, code_q;
   logic is_ar, is_fl, filt_q, fail_q, err_q;

   selftest_mode_dec u_mode (
      .mode_pins (mode_pins),
      .run_o     (run),
      .test_o    (test_en)
   );

   selftest_frame_timer #(.PHASE_LEN(PHASE_LEN), .FRAME_W(FRAME_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .adv     (run && (st_q == ST_RUN)),
      .phase_o (phase_o),
      .frame_o (frame_o),
      .t_end_o (t_end)
   );

   always_comb begin
      code_now = frame_o[CODE_W-1:0];
      is_ar    = (code_now != '0) && (code_now <= AR_HI);
      is_fl    = test_en && (code_now >= FL_LO) && (code_now <= FL_HI);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         code_q <= '0;
         filt_q <= 1'b0;
         fail_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         case (st_q)
            ST_RUN: begin
               if (t_end && (is_ar || is_fl)) begin
                  st_q   <= ST_WAIT;
                  code_q <= code_now;
                  filt_q <= is_fl;
               end
            end
            ST_WAIT: begin
               if (!run) begin
                  st_q <= ST_RUN;
               end else if (filt_q ? filt_done : arith_done) begin
                  fail_q <= filt_q ? filt_fail : arith_fail;
                  st_q   <= ST_UPD;
               end
            end
            ST_UPD: begin
               err_q <= fail_q;
               st_q  <= ST_RUN;
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < N_ARITH; i++) begin : g_asel
         assign arith_sel[i] = (st_q == ST_WAIT) && !filt_q && (code_q == CODE_W'(i + 1));
      end
      for (genvar j = 0; j < N_FILT; j++) begin : g_fsel
         assign filt_sel[j] = (st_q == ST_WAIT) && filt_q && (code_q == CODE_W'(FILT_LO + j));
      end
   endgenerate

   selftest_fail_track #(.N_UNITS(N_UNITS), .CODE_W(CODE_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (st_q == ST_UPD),
      .code     (code_q),
      .fail     (fail_q),
      .status_o (status_o)
   );

   assign err_pulse_o = err_q;
endmodule

// File: rtl/selftest_sched_chk.sv
module selftest_sched_chk #(
   parameter int FRAME_W = 12,
   parameter int N_ARITH = 9,
   parameter int N_FILT  = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [1:0]              mode_pins,
   input logic [FRAME_W-1:0]      frame_o,
   input logic [N_ARITH-1:0]      arith_sel,
   input logic [N_FILT-1:0]       filt_sel,
   input logic [N_ARITH+N_FILT:1] status_o,
   input logic                    err_pulse_o
);
   AST_ONE_TEST_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({filt_sel, arith_sel})); // R5
   AST_FILT_ONLY_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n) $rose(|filt_sel) |-> ($past(mode_pins) == 2'b11)); // R4
   AST_ERR_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) err_pulse_o |=> !err_pulse_o); // R7
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (($past(status_o) & ~status_o) == '0)); // R9
   AST_STATUS_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n) (status_o != $past(status_o)) |-> err_pulse_o); // R6
   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n) ($past(mode_pins[1]) && (frame_o != $past(frame_o))) |-> (frame_o == FRAME_W'($past(frame_o) + 1'b1))); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !mode_pins[1] |=> ((frame_o == '0) && ({filt_sel, arith_sel} == '0))); // R8
endmodule

bind selftest_sched selftest_sched_chk #(
   .FRAME_W (FRAME_W),
   .N_ARITH (N_ARITH),
   .N_FILT  (N_FILT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_pins   (mode_pins),
   .frame_o     (frame_o),
   .arith_sel   (arith_sel),
   .filt_sel    (filt_sel),
   .status_o    (status_o),
   .err_pulse_o (err_pulse_o)
);

// File: tb/tb_selftest_sched.sv
module tb_selftest_sched;
   localparam int PL = 4;
   localparam int FW = 12;
   localparam int CW = 4;
   localparam int NA = 9;
   localparam int NF = 5;
   localparam int NU = NA + NF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'b10;
   logic arith_done = 1'b0, arith_fail = 1'b0, filt_done = 1'b0, filt_fail = 1'b0;
   logic [1:0]    phase_o;
   logic [FW-1:0] frame_o;
   logic [NA-1:0] arith_sel;
   logic [NF-1:0] filt_sel;
   logic [NU:1]   status_o;
   logic          err_pulse_o;

   int checks = 0;
   int fails = 0;
   logic [NU:1] exp_stat = '0;
   bit prev_fail [NU+1];

   always #2 clk = ~clk;

   selftest_sched #(.PHASE_LEN(PL), .FRAME_W(FW), .CODE_W(CW), .N_ARITH(NA), .N_FILT(NF)) dut (
      .clk(clk), .rst_n(rst_n), .mode_pins(mode),
      .arith_done(arith_done), .arith_fail(arith_fail),
      .filt_done(filt_done), .filt_fail(filt_fail),
      .phase_o(phase_o), .frame_o(frame_o), .arith_sel(arith_sel),
      .filt_sel(filt_sel), .status_o(status_o), .err_pulse_o(err_pulse_o)
   );

   task automatic check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic bit pick_fail(int f, int c);
      return (((f / 16) + c) % 3) != 0;
   endfunction

   task automatic run_frame(int f);
      int c, expf, cyc;
      bit want_ar, want_fl, seen, fl;
      logic [NU-1:0] sel, want_sel;
      c = f % 16;
      expf = f % (1 << FW);
      want_ar = (c >= 1) && (c <= NA);
      want_fl = (mode == 2'b11) && (c > NA) && (c <= NU);
      seen = 0;
      cyc = 0;
      check(frame_o == FW'(expf), "R2", "frame number", int'(frame_o), expf);
      while (1) begin
         sel = {filt_sel, arith_sel};
         if (sel != '0 && !seen) begin
            seen = 1;
            want_sel = (c > 0) ? (NU'(1) << (c - 1)) : '0;
            check(want_ar || want_fl, "R5", "select with no test due", int'(sel), 0);
            check(sel == want_sel, want_fl ? "R4" : "R3", "select line", int'(sel), int'(want_sel));
            check(phase_o == 2'd3, "R1", "phase at test start", int'(phase_o), 3);
            fl = pick_fail(f, c);
            for (int k = 0; k < c % 3; k++) begin
               @(negedge clk);
               check(phase_o == 2'd3 && {filt_sel, arith_sel} == want_sel, "R1",
                     "frame frozen while waiting", int'(phase_o), 3);
            end
            if (c > NA) begin filt_done = 1'b1; filt_fail = fl; end
            else begin arith_done = 1'b1; arith_fail = fl; end
            @(negedge clk);
            arith_done = 1'b0; filt_done = 1'b0; arith_fail = 1'b0; filt_fail = 1'b0;
            if (fl && prev_fail[c]) exp_stat[c] = 1'b1;
            prev_fail[c] = fl;
            @(negedge clk);
            check(err_pulse_o == fl, "R7", "error pulse", int'(err_pulse_o), int'(fl));
            check(status_o == exp_stat, "R6", "status after update", int'(status_o), int'(exp_stat));
            @(negedge clk);
            check(err_pulse_o == 1'b0, "R7", "error pulse width", int'(err_pulse_o), 0);
         end else if (!(want_ar || want_fl) && cyc < 4 * PL) begin
            check(phase_o == 2'(cyc / PL), "R1", "phase sequence", int'(phase_o), cyc / PL);
         end
         @(negedge clk);
         cyc++;
         if (frame_o != FW'(expf)) break;
         if (cyc > 200) begin
            check(0, "R1", "frame never ended", cyc, 4 * PL);
            break;
         end
      end
      if (want_ar || want_fl) check(seen, want_fl ? "R4" : "R3", "test not started", 0, 1);
      else check(cyc == 4 * PL, "R1", "idle frame length", cyc, 4 * PL);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i <= NU; i++) prev_fail[i] = 0;
      repeat (3) @(negedge clk);
      check(status_o == '0, "R9", "status in reset", int'(status_o), 0);
      check(err_pulse_o == 1'b0, "R7", "error in reset", int'(err_pulse_o), 0);
      check(frame_o == '0 && {filt_sel, arith_sel} == '0, "R8", "idle in reset", int'(frame_o), 0);
      rst_n = 1'b1;
      for (int f = 0; f < (1 << FW) + 48; f++) begin
         if (f == 48) mode = 2'b11;
         run_frame(f);
      end
      check(exp_stat != '0, "R6", "sweep set some status", int'(exp_stat), 1);
      mode = 2'b01;
      repeat (3) @(negedge clk);
      check(frame_o == '0 && phase_o == 2'd0, "R8", "init mode holds counters", int'(frame_o), 0);
      check({filt_sel, arith_sel} == '0, "R8", "init mode selects", int'({filt_sel, arith_sel}), 0);
      check(status_o == exp_stat, "R9", "status kept in init", int'(status_o), int'(exp_stat));
      mode = 2'b00;
      repeat (3) @(negedge clk);
      check(frame_o == '0 && phase_o == 2'd0, "R8", "reset mode holds counters", int'(frame_o), 0);
      check(status_o == exp_stat, "R9", "status kept in reset mode", int'(status_o), int'(exp_stat));
      mode = 2'b10;
      repeat (2) @(negedge clk);
      check(phase_o == 2'd0 && frame_o == '0, "R8", "restart in normal", int'(phase_o), 0);
      rst_n = 1'b0;
      @(negedge clk);
      check(status_o == '0, "R9", "status cleared by rst_n", int'(status_o), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule